// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial two-wire bus slave that holds a small bank of 8-bit configuration registers for a clock generator. Its parallel outputs drive things like the enable bit of each output clock buffer. A controller normally programs the bank once, at system start. The bank comes out of reset holding a fixed image that is set by a parameter.

Every transfer opens with the device address. On a write, the first byte after the address is a command code, and its top bit picks one of two access styles:

- **Indexed access (top bit set).** The low seven bits of the command name one register. The controller writes a single byte, or reads starting at that register after a repeated start.
- **Block access (top bit clear, low bits zero).** A byte-count byte follows the command. Data then walks the registers upward from register 0, each byte most significant bit first. The controller may stop after any complete byte.

The data line is open-drain. The block only ever pulls it low, through `sda_oe`. Both bus lines are brought into the system clock domain by a two-flop synchroniser. Start and stop conditions are seen as data-line edges while the clock line is high.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave answers only the 7-bit address 0x69, which is byte 0xD2 for a write and 0xD3 for a read. For any other address it leaves the line released during the acknowledge clock, ignores the rest of the transfer up to the next start, and changes no register.
- R2: A command with bit 7 = 1 selects register bits [6:0]. The first data byte of that write is stored there. Any further data bytes in the same write are acknowledged and discarded.
- R3: Indexed read sequence:
  - A write carrying an indexed command, then a repeated start and address 0xD3, returns the selected register.
  - Each byte the controller acknowledges is followed by the next higher register.
- R4: A command of 0x00 selects block mode. The next byte is a count. The following data bytes are stored into registers 0, 1, 2 and upward, and at most count bytes are stored. Any bytes past the count are acknowledged and dropped.
- R5: A block read (command 0x00, then a repeated start and 0xD3) first returns the register count, 8. It then returns registers 0 through 7 in ascending order.
- R6: Offsets of 8 and above are acknowledged, but a write there is discarded and a read there returns 0x00. This applies to indexed accesses and to block transfers that run past register 7.
- R7: If a stop ends a write in the middle of a byte, the partial byte is not stored. Every complete byte before it stays stored.
- R8: The slave pulls the line low during the acknowledge clock of a matching address and of every byte written to it. It changes the line only after a falling clock edge.
- R9: When the controller does not acknowledge a read byte, the slave releases the line and drives nothing more until the next start.
- R10: Reset restores the register image 0x00000000_0F0006FF, with register 0 in the low byte, and releases the line. A stop always releases the line.
- R11: A start seen in any state, including the middle of a byte, abandons the current byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_regs | output | 64 | Register image, register n in bits [8n+7:8n] |

## Verification
The bench goes after the following corner cases, each tied to the failure it would expose:

- **Block transfers past the last register.** A slave with no bound on the pointer would write over an aliased register or return stale data instead of zero.
- **Block count limit.** A slave that ignored the count would store the trailing bytes.
- **Stop in the middle of a byte.** A slave that commits on every bit would corrupt the next register.
- **Restart in the middle of a byte.** A slave that kept its old bit count would shift the address by several bits and miss its own address.
- **Controller not-acknowledge on a read.** A slave that ignored it would keep driving the line and collide with the following stop.
- **Foreign address.** A slave that acknowledged it would take writes meant for another device.

// File: rtl/smb_pkg.sv
// Shared types for the two-wire configuration slave.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package smb_pkg;

    // Protocol engine phases
    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a start
        ST_RX,        // shifting in a byte from the controller
        ST_ACK_WAIT,  // byte done, waiting for the clock to go low
        ST_ACK,       // acknowledge clock in progress
        ST_TX,        // shifting out a byte to the controller
        ST_TX_ACK     // waiting for the controller acknowledge bit
    } link_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_line_sync.sv
// Brings the bus clock and data lines into the system clock domain through a
// STAGES-deep flop chain, then derives clock edges and start/stop conditions.
// Assumes: the system clock is several times faster than the bus clock and
// both lines idle high.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);

    localparam int LAST = STAGES;

    logic [LAST:0] scl_q;
    logic [LAST:0] sda_q;
    logic          scl_s;
    logic          scl_p;
    logic          sda_p;

    // Shift both lines through the synchroniser plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[LAST-1:0], scl_i};
            sda_q <= {sda_q[LAST-1:0], sda_i};
        end
    end

    assign scl_s     = scl_q[LAST-1];
    assign scl_p     = scl_q[LAST];
    assign sda_s     = sda_q[LAST-1];
    assign sda_p     = sda_q[LAST];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_regbank.sv
// Bank of NREG 8-bit configuration registers with one write port and one
// combinational read port. Reads at or above NREG return zero.
// Assumes: writes arrive as single-cycle pulses with an in-range address.
module smb_regbank #(
    parameter int                  NREG        = 8,
    parameter int                  PTRW        = 8,
    parameter logic [NREG*8-1:0]   RESET_IMAGE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [PTRW-1:0]      waddr,
    input  logic [7:0]           wdata,
    input  logic [PTRW-1:0]      raddr,
    output logic [7:0]           rdata,
    output logic [NREG*8-1:0]    q_flat
);

    localparam int              IDXW   = $clog2(NREG);
    localparam logic [PTRW-1:0] NREG_P = PTRW'(NREG);

    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One register: load the reset image, then take matching writes
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= RESET_IMAGE[g*8 +: 8];
            else if (we && waddr == PTRW'(g))
                regs[g] <= wdata;
        end
        assign q_flat[g*8 +: 8] = regs[g];
    end

    // Read mux with zero fill above the last register
    always_comb begin
        if (raddr < NREG_P)
            rdata = regs[raddr[IDXW-1:0]];
        else
            rdata = 8'h00;
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr < NREG_P)); // R6
    AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q_flat)); // R7

endmodule

// File: rtl/smb_link.sv
// Protocol engine: address match, command decode, byte counting, pointer
// auto-increment, acknowledge generation and read data shifting.
// Assumes: synchronised edge strobes from smb_line_sync and a combinational
// read port on the register bank.
module smb_link
    import smb_pkg::*;
#(
    parameter int         NREG     = 8,
    parameter int         PTRW     = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            sda_s,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [7:0]      rdata,
    output logic            sda_oe,
    output logic            we,
    output logic [PTRW-1:0] waddr,
    output logic [7:0]      wdata,
    output logic [PTRW-1:0] raddr
);

    localparam logic [PTRW-1:0]   NREG_P = PTRW'(NREG);
    localparam logic [BYTE_W-1:0] NREG_B = BYTE_W'(NREG);

    link_state_t     state;
    logic [2:0]      bitcnt;
    logic [7:0]      shreg;
    logic [7:0]      txreg;
    logic            addr_phase;
    logic            addr_hit;
    logic            is_read;
    logic            cmd_phase;
    logic            need_count;
    logic            idx_mode;
    logic [6:0]      cmd_off;
    logic [PTRW-1:0] ptr;
    logic [7:0]      wr_left;
    logic            count_due;
    logic            m_ack;

    logic [7:0]      rx_next;
    logic [7:0]      tx_cur;
    logic [PTRW-1:0] ptr_nx;

    assign rx_next = {shreg[6:0], sda_s};
    assign tx_cur  = count_due ? NREG_B : rdata;
    assign ptr_nx  = (ptr == '1) ? ptr : ptr + 1'b1;
    assign raddr   = ptr;

    // Main protocol sequencer; start and stop override every phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            txreg      <= '0;
            addr_phase <= 1'b0;
            addr_hit   <= 1'b0;
            is_read    <= 1'b0;
            cmd_phase  <= 1'b0;
            need_count <= 1'b0;
            idx_mode   <= 1'b0;
            cmd_off    <= '0;
            ptr        <= '0;
            wr_left    <= '0;
            count_due  <= 1'b0;
            m_ack      <= 1'b0;
            sda_oe     <= 1'b0;
            we         <= 1'b0;
            waddr      <= '0;
            wdata      <= '0;
        end else begin
            we <= 1'b0;
            if (start_det) begin
                state      <= ST_RX;
                bitcnt     <= '0;
                addr_phase <= 1'b1;
                sda_oe     <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: if (scl_rise) begin
                        shreg  <= rx_next;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            state <= ST_ACK_WAIT;
                            if (addr_phase) begin
                                addr_hit <= (rx_next[7:1] == DEV_ADDR);
                                is_read  <= rx_next[0];
                                if (rx_next[7:1] == DEV_ADDR) begin
                                    if (rx_next[0]) begin
                                        ptr       <= idx_mode ? PTRW'(cmd_off) : '0;
                                        count_due <= !idx_mode;
                                    end else begin
                                        cmd_phase <= 1'b1;
                                    end
                                end
                            end else if (cmd_phase) begin
                                cmd_phase  <= 1'b0;
                                idx_mode   <= rx_next[7];
                                cmd_off    <= rx_next[6:0];
                                ptr        <= rx_next[7] ? PTRW'(rx_next[6:0]) : '0;
                                need_count <= !rx_next[7];
                                wr_left    <= rx_next[7] ? 8'd1 : 8'd0;
                            end else if (need_count) begin
                                need_count <= 1'b0;
                                wr_left    <= rx_next;
                            end else if (wr_left != 8'd0) begin
                                wr_left <= wr_left - 8'd1;
                                ptr     <= ptr_nx;
                                if (ptr < NREG_P) begin
                                    we    <= 1'b1;
                                    waddr <= ptr;
                                    wdata <= rx_next;
                                end
                            end
                        end
                    end
                    ST_ACK_WAIT: if (scl_fall) begin
                        sda_oe <= addr_phase ? addr_hit : 1'b1;
                        state  <= ST_ACK;
                    end
                    ST_ACK: if (scl_fall) begin
                        addr_phase <= 1'b0;
                        bitcnt     <= '0;
                        if (addr_phase && !addr_hit) begin
                            state  <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end else if (is_read) begin
                            txreg  <= tx_cur;
                            sda_oe <= ~tx_cur[7];
                            state  <= ST_TX;
                            if (count_due) count_due <= 1'b0;
                            else           ptr       <= ptr_nx;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_TX_ACK;
                        end else begin
                            txreg  <= txreg << 1;
                            sda_oe <= ~txreg[6];
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) m_ack <= ~sda_s;
                        if (scl_fall) begin
                            if (m_ack) begin
                                txreg  <= tx_cur;
                                sda_oe <= ~tx_cur[7];
                                state  <= ST_TX;
                                if (count_due) count_due <= 1'b0;
                                else           ptr       <= ptr_nx;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R10
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && bitcnt == 3'd0 && !sda_oe)); // R11
    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && addr_phase && !addr_hit) |-> !sda_oe); // R1
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && scl_fall && !m_ack && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_oe)); // R9
    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)); // R8
    AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX) |-> is_read); // R3

endmodule

// File: rtl/cfg_smbus_slave.sv
// Top of the two-wire configuration slave: synchroniser, protocol engine and
// register bank. Exposes the whole register image in parallel.
// Assumes: open-drain bus with external pull-ups; clk runs at least eight
// times faster than the bus clock.
module cfg_smbus_slave #(
    parameter int                NREG        = 8,
    parameter logic [6:0]        DEV_ADDR    = 7'h69,
    parameter logic [NREG*8-1:0] RESET_IMAGE = 64'h0000_0000_0F00_06FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [NREG*8-1:0]  cfg_regs
);

    localparam int PTRW = 8;

    logic            scl_rise;
    logic            scl_fall;
    logic            sda_s;
    logic            start_det;
    logic            stop_det;
    logic            we;
    logic [PTRW-1:0] waddr;
    logic [7:0]      wdata;
    logic [PTRW-1:0] raddr;
    logic [7:0]      rdata;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_link #(.NREG(NREG), .PTRW(PTRW), .DEV_ADDR(DEV_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (rdata),
        .sda_oe    (sda_oe),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (raddr)
    );

    smb_regbank #(.NREG(NREG), .PTRW(PTRW), .RESET_IMAGE(RESET_IMAGE)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .raddr  (raddr),
        .rdata  (rdata),
        .q_flat (cfg_regs)
    );

endmodule

// File: tb/test_cfg_smbus_slave.sv
`timescale 1ns/1ps
module test_cfg_smbus_slave;

    localparam int          NREG = 8;
    localparam logic [63:0] DEF  = 64'h0000_0000_0F00_06FF;
    localparam int          H    = 16;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        line;
    logic        sda_oe;
    logic [63:0] cfg;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  mreg [NREG];

    always #2 clk = ~clk;
    assign line = m_sda & ~sda_oe;

    cfg_smbus_slave i_cfg_smbus_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg)
    );

    function automatic logic [63:0] model_image();
        logic [63:0] img;
        for (int i = 0; i < NREG; i++) img[i*8 +: 8] = mreg[i];
        return img;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) mreg[i] = DEF[i*8 +: 8];
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model compared with the register outputs on every clock while SCL is low
    always @(posedge clk) begin
        #1;
        if (rst_n && !m_scl) check("R2/R4/R6/R7 register image", cfg, model_image());
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(H);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
        end
    endtask

    // Write one byte; widx names the model register it lands in, or -1
    task automatic write_byte(input logic [7:0] b, input int widx, output logic ack);
        send_bits(b, 8);
        if (widx >= 0 && widx < NREG) mreg[widx] = b;
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H/2);
        ack = ~line; tick(H/2);
        m_scl = 1'b0;
    endtask

    task automatic wb(input logic [7:0] b, input int widx, input string req);
        logic ack;
        write_byte(b, widx, ack);
        check(req, 64'(ack), 64'd1);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H); m_scl = 1'b1; tick(H/2);
            b[i] = line; tick(H/2); m_scl = 1'b0;
        end
        m_sda = ~mack; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0;
    endtask

    initial begin
        logic [7:0] rb;
        logic       ack;
        model_reset();
        tick(6);
        rst_n = 1'b1;
        tick(2);
        check("R10 reset image", cfg, DEF);
        check("R10 line released after reset", 64'(sda_oe), 64'd0);

        // R2 indexed write to register 2
        bus_start(); wb(8'hD2, -1, "R1 write address ack"); wb(8'h82, -1, "R8 command ack");
        wb(8'hA5, 2, "R2 data ack"); bus_stop();
        check("R2 register 2", 64'(cfg[23:16]), 64'hA5);
        // R2 extra byte discarded
        bus_start(); wb(8'hD2, -1, "R8 address ack"); wb(8'h83, -1, "R8 command ack");
        wb(8'h11, 3, "R2 data ack"); wb(8'h22, -1, "R2 extra byte ack"); bus_stop();
        check("R2 register 3", 64'(cfg[31:24]), 64'h11);
        check("R2 register 4 untouched", 64'(cfg[39:32]), 64'h00);

        // R3 indexed read
        bus_start(); wb(8'hD2, -1, "R3 address"); wb(8'h82, -1, "R3 command");
        bus_start(); wb(8'hD3, -1, "R1 read address ack");
        read_byte(1'b0, rb); check("R3 read register 2", 64'(rb), 64'(mreg[2]));
        bus_stop();
        bus_start(); wb(8'hD2, -1, "R3 address"); wb(8'h80, -1, "R3 command");
        bus_start(); wb(8'hD3, -1, "R3 read address");
        read_byte(1'b1, rb); check("R3 read register 0", 64'(rb), 64'(mreg[0]));
        read_byte(1'b0, rb); check("R3 auto-increment register 1", 64'(rb), 64'(mreg[1]));
        bus_stop();

        // R1 foreign address ignored
        bus_start(); write_byte(8'hD4, -1, ack); check("R1 foreign address nack", 64'(ack), 64'd0);
        write_byte(8'h80, -1, ack); check("R1 foreign command ignored", 64'(ack), 64'd0);
        write_byte(8'h55, -1, ack); check("R1 foreign data ignored", 64'(ack), 64'd0);
        bus_stop();
        check("R1 register 0 unchanged", 64'(cfg[7:0]), 64'hFF);

        // R4 block write with count 3 and a fourth byte
        bus_start(); wb(8'hD2, -1, "R4 address"); wb(8'h00, -1, "R4 command");
        wb(8'h03, -1, "R4 count ack");
        wb(8'h10, 0, "R4 data0"); wb(8'h20, 1, "R4 data1"); wb(8'h30, 2, "R4 data2");
        wb(8'h40, -1, "R4 byte past count ack"); bus_stop();
        check("R4 registers 0..3", 64'(cfg[31:0]), 64'h1130_2010);

        // R5 block read then R9 controller nack
        bus_start(); wb(8'hD2, -1, "R5 address"); wb(8'h00, -1, "R5 command");
        bus_start(); wb(8'hD3, -1, "R5 read address");
        read_byte(1'b1, rb); check("R5 count byte", 64'(rb), 64'd8);
        for (int i = 0; i < NREG; i++) begin
            read_byte(i < NREG - 1, rb);
            check("R5 block read data", 64'(rb), 64'(mreg[i]));
        end
        m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H/2);
        check("R9 line high after nack", 64'(line), 64'd1);
        check("R9 no drive after nack", 64'(sda_oe), 64'd0);
        tick(H/2); m_scl = 1'b0;
        bus_stop();

        // R6 out-of-range indexed write and read
        bus_start(); wb(8'hD2, -1, "R6 address"); wb(8'h90, -1, "R6 command");
        wb(8'h77, -1, "R6 out-of-range write ack"); bus_stop();
        bus_start(); wb(8'hD2, -1, "R6 address"); wb(8'h90, -1, "R6 command");
        bus_start(); wb(8'hD3, -1, "R6 read address");
        read_byte(1'b0, rb); check("R6 out-of-range read zero", 64'(rb), 64'd0);
        bus_stop();
        // R6 block write running past the last register
        bus_start(); wb(8'hD2, -1, "R6 address"); wb(8'h00, -1, "R6 command");
        wb(8'h0A, -1, "R6 count");
        for (int i = 0; i < 10; i++) wb(8'hC0 + 8'(i), (i < NREG) ? i : -1, "R6 block byte ack");
        bus_stop();
        check("R6 block write image", cfg, 64'hC7C6C5C4_C3C2C1C0);
        // R6 block read past the last register
        bus_start(); wb(8'hD2, -1, "R6 address"); wb(8'h00, -1, "R6 command");
        bus_start(); wb(8'hD3, -1, "R6 read address");
        read_byte(1'b1, rb);
        for (int i = 0; i < NREG; i++) read_byte(1'b1, rb);
        read_byte(1'b0, rb); check("R6 block read past end zero", 64'(rb), 64'd0);
        bus_stop();

        // R7 stop in the middle of a byte
        bus_start(); wb(8'hD2, -1, "R7 address"); wb(8'h00, -1, "R7 command");
        wb(8'h04, -1, "R7 count"); wb(8'h5A, 0, "R7 full byte");
        send_bits(8'hF0, 4); bus_stop();
        check("R7 full byte kept", 64'(cfg[7:0]), 64'h5A);
        check("R7 partial byte dropped", 64'(cfg[15:8]), 64'hC1);

        // R11 restart in the middle of a byte
        bus_start(); wb(8'hD2, -1, "R11 first address");
        send_bits(8'h80, 3);
        bus_start(); wb(8'hD2, -1, "R11 address after restart");
        wb(8'h83, -1, "R11 command"); wb(8'h99, 3, "R11 data"); bus_stop();
        check("R11 register 3", 64'(cfg[31:24]), 64'h99);

        // R10 reset restores defaults
        tick(4);
        rst_n = 1'b0; model_reset(); tick(4);
        rst_n = 1'b1; tick(2);
        check("R10 image after second reset", cfg, DEF);
        check("R10 line released", 64'(sda_oe), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule